// File: doc/BRIEF.md
# Control Endpoint Status and Interrupt Logic

This block keeps the status bits and interrupt state for endpoint 0 of a full-speed USB device controller. A protocol engine outside the block sends it one-cycle event strobes. The strobes report these events:
- an OUT or SETUP packet was stored;
- an IN packet was sent and acknowledged;
- the status stage finished;
- a protocol violation ended a transaction;
- a control transfer ended early;
- a received packet was corrupted;
- frame start, bus reset, resume and suspend.

The block turns these strobes into sticky status bits and pending flags. It drives one registered interrupt line.

Firmware reaches the state through a small register window with a byte-wide data path. The window has five registers:

| Address | Register | Access |
|---|---|---|
| 0 | Index register | read/write |
| 1 | Endpoint 0 control/status register | reachable only while the index register is 0 |
| 2 | Common interrupt enable register | read/write |
| 3 | Endpoint 0 pending flag | clears on read |
| 4 | Common pending flags | clear on read |

Any other address reads 0. `rdata_o` is combinational and is 0 when `rd_en_i` is low. A read takes effect on the clock edge where `rd_en_i` is high.

The control/status register has five bits:

| Bit | Meaning | Set by | Cleared by |
|---|---|---|---|
| 0 | OUT data ready | hardware | firmware writing 1 |
| 1 | IN data loaded | firmware | hardware, after the IN packet is acknowledged |
| 2 | Stall sent | hardware | firmware writing 1 |
| 3 | Data end | firmware | firmware |
| 4 | Setup ended early | hardware | firmware writing 1 |

Bits 1 and 3 take the written value directly. Bits 7 to 5 read 0.

Top module: `ep0_irq_ctrl`

## Requirements
- R1: After reset, the control/status register reads 0x00 and the index register reads 0x00. The enable register reads 0x06, both pending registers read 0x00, and `irq_o` is 0.
- R2: An OUT/SETUP stored strobe sets control/status bit 0 and the endpoint 0 pending flag. Writing 1 to bit 0 clears it.
- R3: An IN-sent strobe clears control/status bit 1, which firmware sets by writing 1 to it. The strobe also sets the endpoint 0 pending flag.
- R4: A status-stage-done strobe sets the endpoint 0 pending flag and leaves the control/status register unchanged.
- R5: A protocol-violation strobe sets control/status bit 2. The bit stays set through idle cycles until firmware writes 1 to it.
- R6: An early-end strobe with bit 3 at 0 sets bit 4 and the endpoint 0 pending flag. With bit 3 at 1, the strobe changes nothing.
- R7: A corrupted-packet strobe changes no register and no pending flag, and it does not raise `irq_o`.
- R8: The control/status register reads 0x00 and ignores writes while the index register is not 0x00.
- R9: Enable register bits 3, 2, 1 and 0 enable frame start, bus reset, resume and suspend. Bits 7 to 4 read 0 and ignore writes.
- R10: A common event sets its pending bit whatever its enable bit is. It drives `irq_o` only while that enable bit is 1. The pending bits sit at the same positions as the enable bits.
- R11: Reading a pending register clears it. An event arriving in the same cycle as that read leaves its flag set.
- R12: A hardware event in the same cycle as a firmware write to the same control/status bit wins over the write.
- R13: `irq_o` is a register holding the OR of the endpoint 0 pending flag and the enabled common pending flags. It changes on the clock edge that samples the causing strobe, write or read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_out_rx_i | input | 1 | OUT or SETUP packet stored |
| ev_in_sent_i | input | 1 | IN packet sent and acknowledged |
| ev_status_i | input | 1 | Status stage done |
| ev_proto_err_i | input | 1 | Transaction ended by protocol violation |
| ev_early_end_i | input | 1 | Control transfer ended early |
| ev_bad_pkt_i | input | 1 | Corrupted packet received |
| ev_com_i | input | 4 | Frame start, bus reset, resume, suspend (bit 3 to bit 0) |
| addr_i | input | 3 | Register window address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of actions can land in one cycle, and each pair needs its own check.

The first pair is a firmware clear and a hardware event on the same control/status bit. The bench writes 1 to bit 0 in the same cycle as an OUT strobe. It then expects the bit to read back as 1.

The second pair is a read-to-clear and a new event on the same pending flag. The bench reads a pending register while strobing an event that sets it. It expects the old value on `rdata_o` in that cycle and the flag still set on the next read.

The random phase produces both collisions often, and a cycle-level model in the bench judges each one.

// File: rtl/ep0_irq_pkg.sv
package ep0_irq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int N_COM  = 4;

  localparam logic [ADDR_W-1:0] A_INDEX   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CSR     = 3'd1;
  localparam logic [ADDR_W-1:0] A_COM_EN  = 3'd2;
  localparam logic [ADDR_W-1:0] A_EP0_PND = 3'd3;
  localparam logic [ADDR_W-1:0] A_COM_PND = 3'd4;

  localparam int CSR_W = 5;

  typedef struct packed {
    logic send;   // bit 4
    logic dend;   // bit 3
    logic stall;  // bit 2
    logic inpr;   // bit 1
    logic opr;    // bit 0
  } csr_t;
endpackage

// File: rtl/ep0_csr.sv
module ep0_csr
  import ep0_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CSR_W-1:0] wdata_i,
  input  logic             rd_pend_i,
  input  logic             ev_out_rx_i,
  input  logic             ev_in_sent_i,
  input  logic             ev_status_i,
  input  logic             ev_proto_err_i,
  input  logic             ev_early_end_i,
  output csr_t             csr_o,
  output logic             pend_o,
  output logic             pend_n_o,
  output logic             ev_any_o
);
  csr_t csr_q, csr_d;
  logic pend_q;
  logic early_hit;

  assign early_hit = ev_early_end_i & ~csr_q.dend;
  assign ev_any_o  = ev_out_rx_i | ev_in_sent_i | ev_status_i | ev_proto_err_i | early_hit;

  always_comb begin
    csr_d = csr_q;
    if (wr_i) begin
      if (wdata_i[0]) csr_d.opr   = 1'b0;
      csr_d.inpr = wdata_i[1];
      if (wdata_i[2]) csr_d.stall = 1'b0;
      csr_d.dend = wdata_i[3];
      if (wdata_i[4]) csr_d.send  = 1'b0;
    end
    // hardware events win over same-cycle writes
    if (ev_out_rx_i)    csr_d.opr   = 1'b1;
    if (ev_in_sent_i)   csr_d.inpr  = 1'b0;
    if (ev_proto_err_i) csr_d.stall = 1'b1;
    if (early_hit)      csr_d.send  = 1'b1;
  end

  assign pend_n_o = ev_any_o | (pend_q & ~rd_pend_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      csr_q  <= csr_d;
      pend_q <= pend_n_o;
    end
  end

  assign csr_o  = csr_q;
  assign pend_o = pend_q;

  p_opr_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_out_rx_i |=> csr_q.opr);
  p_inpr_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_in_sent_i |=> !csr_q.inpr);
  p_stall_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_q.stall && !(wr_i && wdata_i[2])) |=> csr_q.stall);
  p_setup_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_early_end_i && !csr_q.dend) |=> (csr_q.send && pend_q));
  p_status_pend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_status_i |=> pend_q);
endmodule

// File: rtl/com_irq.sv
module com_irq #(
  parameter int          N      = 4,
  parameter logic [N-1:0] EN_RST = 4'b0110
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_wr_i,
  input  logic [N-1:0] wdata_i,
  input  logic         rd_pend_i,
  input  logic [N-1:0] ev_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] pend_o,
  output logic         act_n_o
);
  logic [N-1:0] en_q, en_d, pend_q, pend_d;

  assign en_d = en_wr_i ? wdata_i : en_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign pend_d[i] = ev_i[i] | (pend_q[i] & ~rd_pend_i);

    p_pend_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i[i] |=> pend_q[i]);
    p_rd_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_pend_i && !ev_i[i]) |=> !pend_q[i]);
  end

  assign act_n_o = |(pend_d & en_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= EN_RST;
      pend_q <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/ep0_irq_ctrl.sv
module ep0_irq_ctrl
  import ep0_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_out_rx_i,
  input  logic              ev_in_sent_i,
  input  logic              ev_status_i,
  input  logic              ev_proto_err_i,
  input  logic              ev_early_end_i,
  input  logic              ev_bad_pkt_i,
  input  logic [N_COM-1:0]  ev_com_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] idx_q;
  logic              idx_zero, wr_csr, wr_en_reg, rd_ep0, rd_com;
  csr_t              csr;
  logic              ep0_pend, ep0_pend_n, ep0_ev;
  logic [N_COM-1:0]  com_en, com_pend;
  logic              com_act_n, irq_q;

  assign idx_zero  = (idx_q == '0);
  assign wr_csr    = wr_en_i && addr_i == A_CSR && idx_zero;
  assign wr_en_reg = wr_en_i && addr_i == A_COM_EN;
  assign rd_ep0    = rd_en_i && addr_i == A_EP0_PND;
  assign rd_com    = rd_en_i && addr_i == A_COM_PND;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          idx_q <= '0;
    else if (wr_en_i && addr_i == A_INDEX) idx_q <= wdata_i;
  end

  ep0_csr u_ep0_csr (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_i           (wr_csr),
    .wdata_i        (wdata_i[CSR_W-1:0]),
    .rd_pend_i      (rd_ep0),
    .ev_out_rx_i    (ev_out_rx_i),
    .ev_in_sent_i   (ev_in_sent_i),
    .ev_status_i    (ev_status_i),
    .ev_proto_err_i (ev_proto_err_i),
    .ev_early_end_i (ev_early_end_i),
    .csr_o          (csr),
    .pend_o         (ep0_pend),
    .pend_n_o       (ep0_pend_n),
    .ev_any_o       (ep0_ev)
  );

  com_irq #(.N(N_COM), .EN_RST(4'b0110)) u_com_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_wr_i   (wr_en_reg),
    .wdata_i   (wdata_i[N_COM-1:0]),
    .rd_pend_i (rd_com),
    .ev_i      (ev_com_i),
    .en_o      (com_en),
    .pend_o    (com_pend),
    .act_n_o   (com_act_n)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        A_INDEX:   rdata_o = idx_q;
        A_CSR:     rdata_o = idx_zero ? DATA_W'(csr) : '0;
        A_COM_EN:  rdata_o = DATA_W'(com_en);
        A_EP0_PND: rdata_o = DATA_W'(ep0_pend);
        A_COM_PND: rdata_o = DATA_W'(com_pend);
        default:   rdata_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= ep0_pend_n | com_act_n;
  end
  assign irq_o = irq_q;

  p_irq_track_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (ep0_pend | |(com_pend & com_en)));
  p_bad_pkt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_bad_pkt_i && !ep0_ev && !wr_csr && !rd_ep0) |=> ($stable(csr) && $stable(ep0_pend)));
  p_index_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idx_zero && !ep0_ev) |=> $stable(csr));
endmodule

// File: tb/ep0_irq_ctrl_bench.sv
module ep0_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ev_out, ev_in, ev_st, ev_pe, ev_ee, ev_bad;
  logic [3:0] ev_com;
  logic [2:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wdata, rdata;
  logic       irq;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // reference state
  logic [7:0] m_idx;
  logic       m_opr, m_inpr, m_stall, m_dend, m_send, m_ep0p, m_irq;
  logic [3:0] m_en, m_comp;

  logic       dir_en;
  logic [7:0] dir_exp;
  string      dir_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep0_irq_ctrl u_ep0_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .ev_out_rx_i(ev_out), .ev_in_sent_i(ev_in), .ev_status_i(ev_st),
    .ev_proto_err_i(ev_pe), .ev_early_end_i(ev_ee), .ev_bad_pkt_i(ev_bad),
    .ev_com_i(ev_com), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: act=%0d exp<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(logic [2:0] a);
    if (!rd_en) return 8'h00;
    case (a)
      3'd0: return m_idx;
      3'd1: return (m_idx == 0) ? {3'b0, m_send, m_dend, m_stall, m_inpr, m_opr} : 8'h00;
      3'd2: return {4'b0, m_en};
      3'd3: return {7'b0, m_ep0p};
      3'd4: return {4'b0, m_comp};
      default: return 8'h00;
    endcase
  endfunction

  task automatic clr_inputs();
    {ev_out, ev_in, ev_st, ev_pe, ev_ee, ev_bad} = '0;
    ev_com = '0; addr = '0; wr_en = 0; rd_en = 0; wdata = '0;
  endtask

  // called just after a negedge with inputs applied
  task automatic tick();
    logic wc, hit, ep0ev;
    logic n_opr, n_inpr, n_stall, n_dend, n_send, n_ep0p;
    logic [3:0] n_en, n_comp;
    logic [7:0] n_idx;
    #2;
    chk((addr == 3'd1) ? "R8" : (addr == 3'd3) ? "R11" : (addr == 3'd4) ? "R10" : "R9",
        rdata, m_read(addr));
    chk("R13", {7'b0, irq}, {7'b0, m_irq});
    if (dir_en) chk(dir_tag, rdata, dir_exp);
    dir_en = 0;
    wc    = wr_en && addr == 3'd1 && m_idx == 0;
    hit   = ev_ee && !m_dend;
    ep0ev = ev_out | ev_in | ev_st | ev_pe | hit;
    n_opr   = ev_out ? 1'b1 : (wc && wdata[0]) ? 1'b0 : m_opr;
    n_inpr  = ev_in  ? 1'b0 : wc ? wdata[1] : m_inpr;
    n_stall = ev_pe  ? 1'b1 : (wc && wdata[2]) ? 1'b0 : m_stall;
    n_dend  = wc ? wdata[3] : m_dend;
    n_send  = hit    ? 1'b1 : (wc && wdata[4]) ? 1'b0 : m_send;
    n_ep0p  = ep0ev | (m_ep0p & !(rd_en && addr == 3'd3));
    n_en    = (wr_en && addr == 3'd2) ? wdata[3:0] : m_en;
    n_comp  = ev_com | (m_comp & {4{!(rd_en && addr == 3'd4)}});
    n_idx   = (wr_en && addr == 3'd0) ? wdata : m_idx;
    @(posedge clk); #1;
    m_opr = n_opr; m_inpr = n_inpr; m_stall = n_stall; m_dend = n_dend; m_send = n_send;
    m_ep0p = n_ep0p; m_en = n_en; m_comp = n_comp; m_idx = n_idx;
    m_irq = n_ep0p | |(n_comp & n_en);
    @(negedge clk);
    clr_inputs();
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    addr = a; wr_en = 1; wdata = d; tick();
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] e, string tag);
    addr = a; rd_en = 1; dir_en = 1; dir_exp = e; dir_tag = tag; tick();
  endtask

  task automatic irq_is(logic e, string tag);
    chk(tag, {7'b0, irq}, {7'b0, e});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clr_inputs(); dir_en = 0;
    m_idx = 0; {m_opr, m_inpr, m_stall, m_dend, m_send, m_ep0p, m_irq} = '0;
    m_en = 4'h6; m_comp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    irq_is(0, "R1");
    rd(3'd2, 8'h06, "R1"); rd(3'd1, 8'h00, "R1"); rd(3'd4, 8'h00, "R1"); rd(3'd0, 8'h00, "R1");
    // R2 / R13 / R11
    ev_out = 1; tick();
    irq_is(1, "R13");
    rd(3'd1, 8'h01, "R2");
    rd(3'd3, 8'h01, "R11"); rd(3'd3, 8'h00, "R11");
    irq_is(0, "R11");
    // R12 event beats clear
    ev_out = 1; wr(3'd1, 8'h01);
    rd(3'd1, 8'h01, "R12"); rd(3'd3, 8'h01, "R12");
    wr(3'd1, 8'h01); rd(3'd1, 8'h00, "R2");
    // R3
    wr(3'd1, 8'h02); rd(3'd1, 8'h02, "R3");
    ev_in = 1; tick();
    rd(3'd1, 8'h00, "R3"); rd(3'd3, 8'h01, "R3");
    // R4
    ev_st = 1; tick();
    rd(3'd1, 8'h00, "R4"); rd(3'd3, 8'h01, "R4");
    // R5
    ev_pe = 1; tick();
    rd(3'd3, 8'h01, "R5");
    repeat (3) tick();
    rd(3'd1, 8'h04, "R5");
    wr(3'd1, 8'h04); rd(3'd1, 8'h00, "R5");
    // R6
    ev_ee = 1; tick();
    rd(3'd1, 8'h10, "R6"); rd(3'd3, 8'h01, "R6");
    wr(3'd1, 8'h10); wr(3'd1, 8'h08);
    ev_ee = 1; tick();
    irq_is(0, "R6");
    rd(3'd1, 8'h08, "R6"); rd(3'd3, 8'h00, "R6");
    wr(3'd1, 8'h00);
    // R7
    ev_bad = 1; tick();
    irq_is(0, "R7");
    rd(3'd1, 8'h00, "R7"); rd(3'd3, 8'h00, "R7"); rd(3'd4, 8'h00, "R7");
    // R8
    wr(3'd0, 8'h02); wr(3'd1, 8'h0A);
    rd(3'd1, 8'h00, "R8");
    wr(3'd0, 8'h00); rd(3'd1, 8'h00, "R8");
    // R9
    wr(3'd2, 8'hFF); rd(3'd2, 8'h0F, "R9");
    wr(3'd2, 8'h00);
    // R10
    ev_com = 4'b1000; tick();
    irq_is(0, "R10");
    rd(3'd4, 8'h08, "R10");
    wr(3'd2, 8'h01);
    ev_com = 4'b0001; tick();
    irq_is(1, "R10");
    rd(3'd4, 8'h01, "R10");
    irq_is(0, "R10");
    // R11 event during read-clear
    ev_com = 4'b0010; rd(3'd4, 8'h00, "R11");
    rd(3'd4, 8'h02, "R11");
    ev_st = 1; rd(3'd3, 8'h00, "R11");
    rd(3'd3, 8'h01, "R11");
    wr(3'd2, 8'h06);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      ev_out = ($urandom % 8) == 0;
      ev_in  = ($urandom % 8) == 0;
      ev_st  = ($urandom % 8) == 0;
      ev_pe  = ($urandom % 10) == 0;
      ev_ee  = ($urandom % 8) == 0;
      ev_bad = ($urandom % 6) == 0;
      for (int b = 0; b < 4; b++) ev_com[b] = ($urandom % 9) == 0;
      addr  = 3'($urandom % 6);
      wr_en = ($urandom % 3) == 0;
      rd_en = ($urandom % 2) == 0;
      wdata = 8'($urandom);
      if (addr == 3'd0 && ($urandom % 4) != 0) wdata = 8'h00;
      tick();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule